// File: doc/BRIEF.md
# Serial Command Decoder for a Dual Digital Potentiometer

This block is the serial slave front end of a two-channel digital potentiometer. A host selects the device by pulling chip select low, clocks bytes in on SI and reads replies on SO. The first byte names the device: a fixed 4-bit type code and a 2-bit address that must match two strap pins. The second byte carries an opcode, a data-register index and a potentiometer index. What follows depends on the command: a value byte written or read, nothing at all for a register transfer, or an open-ended burst of single-step wiper moves.

The block holds the two volatile wiper positions and a shadow of the four data registers per channel. It drives the wiper positions straight to the resistor-array decoders. Every change to a data register raises a one-cycle request to the nonvolatile-store sequencer. That sequencer reports back through a busy input, and the busy input is what read status returns. All serial pins are sampled with the block clock, which must run several times faster than SCK. A HOLD input pauses a frame partway through without losing its place.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset no command is accepted until chip select has gone from high to low. A frame whose chip select was already low when reset was released changes nothing.
- R2: SI is taken on each rising SCK edge and SO changes only after falling SCK edges. A read reply is sent MSB first in the byte after the instruction. The reply is two zero bits followed by the 6-bit value.
- R3: so_oe is low whenever cs_n is high. It is also low in every frame that is not an accepted read, status read included.
- R4: The first byte must be 0101 in bits 7..4, 00 in bits 3..2 and the strap address in bits 1..0. On any mismatch the whole frame is ignored.
- R5: In the instruction byte, bits 7..4 are the opcode, bits 3..2 pick a data register, bit 1 must be 0 and bit 0 picks the potentiometer. The valid opcodes are:
  - 1001 read wiper
  - 1010 write wiper
  - 1011 read data register
  - 1100 write data register
  - 1101 data register to wiper
  - 1110 wiper to data register
  - 0010 step burst
  - 0001 all data registers to wipers
  - 1000 all wipers to data registers
  - 0101 status

  Any other opcode, or bit 1 set, makes the frame be ignored.
- R6: A write-wiper or write-register frame of exactly 24 bits loads bits 5..0 of its third byte when chip select rises.
- R7: A transfer frame of exactly 16 bits copies between the selected wiper and data register when chip select rises. The global forms do this for both channels with the same register index.
- R8: Each data-register change pulses nv_req for one cycle after chip select rises. With it come nv_all (global), nv_pot, nv_sel and nv_data = {channel 1 value, channel 0 value} of the selected register. While wp_n is low, every data-register change is suppressed and no request is made.
- R9: After a step-burst instruction, each rising SCK edge moves the selected wiper one step. It moves up when SI is 1 and down when SI is 0, and it holds at 63 and at 0.
- R10: A load or transfer frame shorter or longer than its exact length changes nothing and issues no request.
- R11: While nv_busy is high at the end of the instruction byte, only status is accepted. Status replies 0000000 followed by the busy bit.
- R12: hold_n taken low while SCK is low pauses the frame. SCK edges are then ignored and so_oe is low. hold_n taken high while SCK is low resumes the frame at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause |
| addr_strap | input | 2 | Strap address compared against the first byte |
| wp_n | input | 1 | Active-low nonvolatile write protect |
| nv_busy | input | 1 | Store sequencer busy (write in progress) |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| wiper_pos | output | 12 | {channel 1, channel 0} wiper positions |
| nv_req | output | 1 | One-cycle store request |
| nv_all | output | 1 | Request is the global form |
| nv_pot | output | 1 | Channel of a single store |
| nv_sel | output | 2 | Data-register index to store |
| nv_data | output | 12 | Values to store, {channel 1, channel 0} |

## Verification
The address check is swept over all sixteen pairings of strap and sent address, so a single wrong comparison bit shows up as a wiper that moved when it should not, or stayed when it should have moved. Every data register of both channels is written with a distinct value and read back, so crossed channel or register indexing is caught. The step bursts run into both ends of the range, which separates saturation from wrap-around. Unknown opcodes, frames cut short or run long, write protect, busy and a mid-frame pause each follow a known good state, so any stray load shows as a changed wiper, a changed read-back or an extra store request.

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl #(
  parameter int          VAL_W    = 6,
  parameter logic [3:0]  DEV_TYPE = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               si,
  input  logic               cs_n,
  input  logic               hold_n,
  input  logic [1:0]         addr_strap,
  input  logic               wp_n,
  input  logic               nv_busy,
  output logic               so,
  output logic               so_oe,
  output logic [2*VAL_W-1:0] wiper_pos,
  output logic               nv_req,
  output logic               nv_all,
  output logic               nv_pot,
  output logic [1:0]         nv_sel,
  output logic [2*VAL_W-1:0] nv_data
);
  localparam logic [3:0] OP_RDW  = 4'b1001, OP_WRW  = 4'b1010, OP_RDD = 4'b1011,
                         OP_WRD  = 4'b1100, OP_D2W  = 4'b1101, OP_W2D = 4'b1110,
                         OP_STEP = 4'b0010, OP_GD2W = 4'b0001, OP_GW2D = 4'b1000,
                         OP_STAT = 4'b0101;
  localparam logic [VAL_W-1:0] MAXV = '1;
  localparam logic [VAL_W-1:0] ONE  = 1;
  localparam int PADW = 8 - VAL_W;

  function automatic logic known_op(input logic [3:0] o);
    case (o)
      OP_RDW, OP_WRW, OP_RDD, OP_WRD, OP_D2W, OP_W2D,
      OP_STEP, OP_GD2W, OP_GW2D, OP_STAT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic             sck_q, cs_q, armed, paused, bad, rd_phase, so_q;
  logic [4:0]       cnt;
  logic [6:0]       sh;
  logic [3:0]       op;
  logic [1:0]       rsel;
  logic             pot;
  logic [VAL_W-1:0] dat;
  logic [7:0]       rdat;
  logic [VAL_W-1:0] wcr [2];
  logic [VAL_W-1:0] dr  [2][4];

  wire       active  = armed & ~cs_n;
  wire       rise    = active & ~paused & sck & ~sck_q;
  wire       fall    = active & ~paused & ~sck & sck_q;
  wire       cs_rise = armed & cs_n & ~cs_q;
  wire [7:0] byte_in = {sh, si};
  wire [3:0] op_in   = byte_in[7:4];
  wire       id_ok   = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:2] == 2'b00) &&
                       (byte_in[1:0] == addr_strap);
  wire       ins_ok  = known_op(op_in) && !byte_in[1] && (!nv_busy || op_in == OP_STAT);
  wire       is_rd   = (op == OP_RDW) || (op == OP_RDD) || (op == OP_STAT);
  wire       step_en = rise && !bad && (op == OP_STEP) && (cnt >= 5'd16);

  wire exec    = cs_rise && !bad;
  wire len16   = (cnt == 5'd16);
  wire len24   = (cnt == 5'd24);
  wire do_wrw  = exec && (op == OP_WRW)  && len24;
  wire do_wrd  = exec && (op == OP_WRD)  && len24 && wp_n;
  wire do_d2w  = exec && (op == OP_D2W)  && len16;
  wire do_w2d  = exec && (op == OP_W2D)  && len16 && wp_n;
  wire do_gd2w = exec && (op == OP_GD2W) && len16;
  wire do_gw2d = exec && (op == OP_GW2D) && len16 && wp_n;
  wire do_st   = do_wrd | do_w2d | do_gw2d;

  logic [7:0] rd_mux;
  always_comb begin
    case (op_in)
      OP_RDW:  rd_mux = {{PADW{1'b0}}, wcr[byte_in[0]]};
      OP_RDD:  rd_mux = {{PADW{1'b0}}, dr[byte_in[0]][byte_in[3:2]]};
      OP_STAT: rd_mux = {7'b0, nv_busy};
      default: rd_mux = 8'h00;
    endcase
  end

  // serial frame sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b0; armed <= 1'b0; paused <= 1'b0;
      bad <= 1'b0; rd_phase <= 1'b0; so_q <= 1'b0; cnt <= '0; sh <= '0;
      op <= '0; rsel <= '0; pot <= 1'b0; dat <= '0; rdat <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (!cs_n && cs_q) armed <= 1'b1;
      if (cs_n) begin
        cnt <= '0; bad <= 1'b0; rd_phase <= 1'b0; paused <= 1'b0; so_q <= 1'b0;
      end else if (active) begin
        if (!paused && !hold_n && !sck)    paused <= 1'b1;
        else if (paused && hold_n && !sck) paused <= 1'b0;
        if (rise) begin
          sh <= byte_in[6:0];
          if (cnt != 5'd31) cnt <= cnt + 5'd1;
          if (cnt == 5'd7 && !id_ok) bad <= 1'b1;
          if (cnt == 5'd15 && !bad) begin
            op   <= op_in;
            rsel <= byte_in[3:2];
            pot  <= byte_in[0];
            rdat <= rd_mux;
            if (!ins_ok) bad <= 1'b1;
          end
          if (cnt == 5'd23) dat <= byte_in[VAL_W-1:0];
        end
        if (fall && !bad && is_rd && cnt >= 5'd16) begin
          rd_phase <= 1'b1;
          so_q     <= (cnt <= 5'd23) ? rdat[~cnt[2:0]] : 1'b0;
        end
      end
    end
  end

  // wiper and data register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        wcr[p] <= '0;
        for (int r = 0; r < 4; r++) dr[p][r] <= '0;
      end
    end else begin
      if (step_en) begin
        if (si && wcr[pot] != MAXV)      wcr[pot] <= wcr[pot] + ONE;
        else if (!si && wcr[pot] != '0) wcr[pot] <= wcr[pot] - ONE;
      end
      if (do_wrw) wcr[pot] <= dat;
      if (do_d2w) wcr[pot] <= dr[pot][rsel];
      if (do_wrd) dr[pot][rsel] <= dat;
      if (do_w2d) dr[pot][rsel] <= wcr[pot];
      for (int p = 0; p < 2; p++) begin
        if (do_gd2w) wcr[p] <= dr[p][rsel];
        if (do_gw2d) dr[p][rsel] <= wcr[p];
      end
    end
  end

  // store requests
  wire [VAL_W-1:0] store_val = do_wrd ? dat : wcr[pot];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_req <= 1'b0; nv_all <= 1'b0; nv_pot <= 1'b0; nv_sel <= '0; nv_data <= '0;
    end else begin
      nv_req <= do_st;
      if (do_st) begin
        nv_all <= do_gw2d;
        nv_pot <= pot;
        nv_sel <= rsel;
        for (int p = 0; p < 2; p++)
          nv_data[p*VAL_W +: VAL_W] <= do_gw2d ? wcr[p] :
                                       (pot == 1'(p)) ? store_val : dr[p][rsel];
      end
    end
  end

  assign so        = so_q;
  assign so_oe     = rd_phase & ~paused & ~cs_n;
  assign wiper_pos = {wcr[1], wcr[0]};

  a_r1_idle_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cnt == 5'd0 && !rd_phase));
  a_r2_reply_starts_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_phase) |-> (cnt == 5'd16));
  a_r8_req_follows_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> $past(cs_n));
  a_r8_req_needs_wp_high: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> $past(wp_n));
  a_r9_step_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && si && !pot && wcr[0] == MAXV) |=> (wcr[0] == MAXV));
  a_r12_pause_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_n) |=> $stable(cnt));
endmodule

// File: tb/dpot_spi_ctrl_tb_top.sv
module dpot_spi_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 3;

  logic clk = 0, rst_n = 0, sck = 0, si = 0, cs_n = 0, hold_n = 1, wp_n = 1, nv_busy = 0;
  logic [1:0] addr_strap = 2'd0;
  logic so, so_oe, nv_req, nv_all, nv_pot;
  logic [1:0] nv_sel;
  logic [11:0] wiper_pos, nv_data;

  dpot_spi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .addr_strap(addr_strap), .wp_n(wp_n), .nv_busy(nv_busy), .so(so), .so_oe(so_oe),
    .wiper_pos(wiper_pos), .nv_req(nv_req), .nv_all(nv_all), .nv_pot(nv_pot),
    .nv_sel(nv_sel), .nv_data(nv_data));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, oe_hits = 0, reqs = 0, bitno = 0, hold_at = -1;
  logic last_all, last_pot;
  logic [1:0] last_sel;
  logic [11:0] last_data;
  logic [5:0] wcr_m [2];
  logic [5:0] dr_m [2][4];

  always @(negedge clk) if (nv_req) begin
    reqs++; last_all = nv_all; last_pot = nv_pot; last_sel = nv_sel; last_data = nv_data;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] idb(input logic [1:0] a); return {4'b0101, 2'b00, a}; endfunction
  function automatic logic [7:0] ins(input logic [3:0] o, input logic [1:0] r, input logic p);
    return {o, r, 1'b0, p};
  endfunction

  task automatic sbit(input logic b, output logic got);
    if (bitno == hold_at) begin
      hold_n = 0; repeat (2) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        si = ~si; sck = 1; repeat (HALF) @(negedge clk); sck = 0; repeat (HALF) @(negedge clk);
      end
      check("R12 output released while paused", so_oe, 0);
      hold_n = 1; repeat (2) @(negedge clk);
    end
    si = b; repeat (HALF) @(negedge clk);
    got = so; if (so_oe) oe_hits++;
    sck = 1; repeat (HALF) @(negedge clk); sck = 0; bitno++;
  endtask

  task automatic bytex(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin logic g; sbit(b[i], g); got[i] = g; end
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                       input int nb, output logic [7:0] rd);
    logic [7:0] t;
    cs_n = 0; bitno = 0; repeat (2) @(negedge clk);
    bytex(a, t);
    if (nb > 1) bytex(c, t);
    rd = 8'h00;
    if (nb > 2) bytex(d, rd);
    if (nb > 3) bytex(d, t);
    repeat (2) @(negedge clk); cs_n = 1; repeat (4) @(negedge clk);
  endtask

  function automatic int wexp(); return {wcr_m[1], wcr_m[0]}; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, t;
    int r0, o0;
    for (int p = 0; p < 2; p++) begin wcr_m[p] = 0; for (int r = 0; r < 4; r++) dr_m[p][r] = 0; end
    repeat (3) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    check("R3 reset output enable", so_oe, 0);
    check("R8 reset request", nv_req, 0);
    check("R1 reset wiper", wiper_pos, 0);

    // R1: chip select low across reset, no falling edge seen
    bitno = 0;
    bytex(idb(0), t); bytex(ins(4'b1010, 0, 0), t); bytex(8'h15, t);
    repeat (2) @(negedge clk); cs_n = 1; repeat (4) @(negedge clk);
    check("R1 frame without select fall ignored", wiper_pos, 0);
    check("R1 no request", reqs, 0);

    // R4: address sweep
    for (int s = 0; s < 4; s++) begin
      addr_strap = 2'(s);
      for (int a = 0; a < 4; a++) begin
        logic [5:0] v;
        v = 6'(s * 4 + a + 1);
        frame(idb(2'(a)), ins(4'b1010, 0, 1'(a)), {2'b00, v}, 3, rd);
        if (a == s) wcr_m[a % 2] = v;
        check($sformatf("R4 strap %0d id %0d", s, a), wiper_pos, wexp());
      end
    end
    addr_strap = 2'd2;
    frame(8'h62, ins(4'b1010, 0, 0), 8'h3F, 3, rd);
    check("R4 wrong type code", wiper_pos, wexp());
    check("R3 idle after deselect", so_oe, 0);

    // R6/R8/R2: every data register written and read back
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) begin
        logic [5:0] v;
        v = 6'(7 + p * 20 + r * 9);
        r0 = reqs; o0 = oe_hits;
        frame(idb(2), ins(4'b1100, 2'(r), 1'(p)), {2'b11, v}, 3, rd);
        dr_m[p][r] = v;
        check("R8 one request per write", reqs - r0, 1);
        check("R8 request fields", {last_all, last_pot, last_sel}, {1'b0, 1'(p), 2'(r)});
        check("R8 request data", last_data, {dr_m[1][r], dr_m[0][r]});
        check("R3 no output on write", oe_hits - o0, 0);
      end
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) begin
        frame(idb(2), ins(4'b1011, 2'(r), 1'(p)), 8'h00, 3, rd);
        check($sformatf("R2 read register p%0d r%0d", p, r), rd, {2'b00, dr_m[p][r]});
      end
    frame(idb(2), ins(4'b1001, 0, 1), 8'h00, 3, rd);
    check("R2 read wiper", rd, {2'b00, wcr_m[1]});

    // R7 transfers
    frame(idb(2), ins(4'b1101, 2, 1), 0, 2, rd); wcr_m[1] = dr_m[1][2];
    check("R7 register to wiper", wiper_pos, wexp());
    r0 = reqs;
    frame(idb(2), ins(4'b1110, 3, 0), 0, 2, rd); dr_m[0][3] = wcr_m[0];
    check("R7 wiper to register request", reqs - r0, 1);
    check("R8 single store data", last_data, {dr_m[1][3], dr_m[0][3]});
    frame(idb(2), ins(4'b1011, 3, 0), 0, 3, rd);
    check("R7 wiper to register readback", rd, {2'b00, dr_m[0][3]});
    frame(idb(2), ins(4'b0001, 1, 0), 0, 2, rd);
    wcr_m[0] = dr_m[0][1]; wcr_m[1] = dr_m[1][1];
    check("R7 global register to wiper", wiper_pos, wexp());
    wcr_m[0] = 6'd50;
    frame(idb(2), ins(4'b1010, 0, 0), 8'd50, 3, rd);
    frame(idb(2), ins(4'b1000, 0, 0), 0, 2, rd);
    dr_m[0][0] = wcr_m[0]; dr_m[1][0] = wcr_m[1];
    check("R8 global store fields", {last_all, last_sel}, {1'b1, 2'd0});
    check("R8 global store data", last_data, {wcr_m[1], wcr_m[0]});

    // R8 write protect
    wp_n = 0; r0 = reqs;
    frame(idb(2), ins(4'b1100, 0, 1), 8'd33, 3, rd);
    frame(idb(2), ins(4'b1000, 2, 0), 0, 2, rd);
    frame(idb(2), ins(4'b1110, 2, 0), 0, 2, rd);
    check("R8 protected, no request", reqs - r0, 0);
    frame(idb(2), ins(4'b1011, 0, 1), 0, 3, rd);
    check("R8 protected register kept", rd, {2'b00, dr_m[1][0]});
    frame(idb(2), ins(4'b1101, 0, 1), 0, 2, rd); wcr_m[1] = dr_m[1][0];
    check("R8 protect leaves wiper load", wiper_pos, wexp());
    wp_n = 1;

    // R9 step bursts into both limits
    frame(idb(2), ins(4'b1010, 0, 0), 8'd61, 3, rd); wcr_m[0] = 61;
    cs_n = 0; bitno = 0; repeat (2) @(negedge clk);
    bytex(idb(2), t); bytex(ins(4'b0010, 0, 0), t);
    for (int k = 0; k < 7; k++) begin
      logic b, g;
      b = (k < 4);
      sbit(b, g); repeat (1) @(negedge clk);
      if (b) wcr_m[0] = (wcr_m[0] == 63) ? 6'd63 : wcr_m[0] + 1;
      else   wcr_m[0] = (wcr_m[0] == 0)  ? 6'd0  : wcr_m[0] - 1;
      check($sformatf("R9 step %0d top", k), wiper_pos, wexp());
    end
    cs_n = 1; repeat (4) @(negedge clk);
    frame(idb(2), ins(4'b1010, 0, 1), 8'd1, 3, rd); wcr_m[1] = 1;
    cs_n = 0; bitno = 0; repeat (2) @(negedge clk);
    bytex(idb(2), t); bytex(ins(4'b0010, 0, 1), t);
    for (int k = 0; k < 3; k++) begin
      logic g;
      sbit(1'b0, g); repeat (1) @(negedge clk);
      wcr_m[1] = (wcr_m[1] == 0) ? 6'd0 : wcr_m[1] - 1;
      check($sformatf("R9 step %0d bottom", k), wiper_pos, wexp());
    end
    cs_n = 1; repeat (4) @(negedge clk);

    // R5 unknown opcodes and reserved bit
    r0 = reqs;
    for (int o = 0; o < 16; o++) begin
      if (o == 4'b0000 || o == 4'b0011 || o == 4'b0100 || o == 4'b0110 ||
          o == 4'b0111 || o == 4'b1111) begin
        frame(idb(2), ins(4'(o), 0, 0), 8'h2A, 3, rd);
        frame(idb(2), ins(4'(o), 0, 0), 8'h2A, 2, rd);
        check($sformatf("R5 opcode %0d ignored", o), wiper_pos, wexp());
      end
    end
    frame(idb(2), 8'b1010_0010, 8'h2A, 3, rd);
    check("R5 reserved bit set ignored", wiper_pos, wexp());
    check("R5 no request", reqs - r0, 0);

    // R10 wrong lengths
    frame(idb(2), ins(4'b1010, 0, 0), 8'h11, 2, rd);
    frame(idb(2), ins(4'b1010, 0, 0), 8'h11, 4, rd);
    frame(idb(2), ins(4'b1101, 3, 1), 8'h00, 3, rd);
    check("R10 short/long loads ignored", wiper_pos, wexp());
    r0 = reqs;
    frame(idb(2), ins(4'b1100, 1, 0), 8'h05, 2, rd);
    frame(idb(2), ins(4'b1110, 1, 0), 8'h05, 3, rd);
    check("R10 no request", reqs - r0, 0);

    // R11 busy
    nv_busy = 1;
    frame(idb(2), ins(4'b0101, 0, 0), 0, 3, rd);
    check("R11 status busy", rd, 8'h01);
    frame(idb(2), ins(4'b1010, 0, 1), 8'd9, 3, rd);
    check("R11 write refused while busy", wiper_pos, wexp());
    o0 = oe_hits;
    frame(idb(2), ins(4'b1001, 0, 0), 0, 3, rd);
    check("R11 read refused while busy", oe_hits - o0, 0);
    nv_busy = 0;
    frame(idb(2), ins(4'b0101, 0, 0), 0, 3, rd);
    check("R11 status idle", rd, 8'h00);

    // R12 pause mid-frame: in the instruction byte and in a reply
    hold_at = 10;
    frame(idb(2), ins(4'b1010, 0, 1), 8'd44, 3, rd); wcr_m[1] = 44;
    check("R12 write resumes intact", wiper_pos, wexp());
    hold_at = 19;
    frame(idb(2), ins(4'b1011, 2, 1), 0, 3, rd);
    check("R12 read resumes intact", rd, {2'b00, dr_m[1][2]});
    hold_at = -1;
    check("R3 released after frames", so_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule